// File: doc/BRIEF.md
# Descriptor-Chained Three-Dimensional Memory-to-Stream Mover

The block reads words out of a local memory and sends them, one 32-bit word per beat, on a valid/ready output stream. The order of the reads is set by a three-dimensional address pattern. Each dimension has its own element count and its own address step, and the innermost dimension runs fastest. One transfer is described entirely by one entry of an eight-entry descriptor table. Software fills the table through a plain write port, one field per write. A pulse on `start` names the first entry. An entry can name a follow-on entry, and the mover then continues with that entry on its own. A one-cycle `done` pulse closes the chain.

The memory read port is synchronous with one cycle of latency. Read data goes into a two-entry output stage, made of an output register and a skid register. This lets the block issue a read every cycle while the stream accepts every beat. When the stream stalls, no new read is issued until a slot is free, so the block never drops or overwrites a word. Back-pressure rules on the stream: once `m_valid` is high it stays high, and `m_data` stays unchanged, until a cycle with `m_ready` high. A beat moves only on a rising edge where both signals are high. `m_ready` may change freely, and `m_valid` never depends on it combinationally.

Top module: `dma_mm2s_mover`

## Requirements
- R1: Every beat carries the 32-bit memory word read at the generated address. Beats come out in generation order, with no word lost or repeated.
- R2: Beat n of a descriptor reads address (base + i0*step0 + i1*step1 + i2*step2) mod 2^12. i0 is the innermost index, and the indices wrap in the order i0, then i1, then i2.
- R3: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` stays stable into the next cycle.
- R4: Within one descriptor, with `m_ready` held high, consecutive beats are accepted on consecutive cycles (one word per cycle).
- R5: `mem_en` is asserted only while `busy` is high. The read address is presented in the cycle `mem_en` is high, and the data is expected on `mem_rdata` in the following cycle.
- R6: If an entry's link field has its enable bit set, the entry named by the link index runs next, without a new `start`.
- R7: If any of the three counts of an entry is zero, that entry produces no beats. Its link, if any, is still followed.
- R8: `done` is high for exactly one cycle. That cycle directly follows the acceptance of the final beat of a chain, or follows the load of a final empty entry. `busy` is low in the next cycle.
- R9: A `start` pulse that arrives while `busy` is high is ignored. It adds no beats and no extra `done`.
- R10: Field codes on the table write port, with the low bits of `cfg_wdata` taken: 0 = base (12 bits), 1/2/3 = count of dimension 0/1/2 (8 bits), 4/5/6 = step of dimension 0/1/2 (12 bits), 7 = link (bit 3 = enable, bits 2:0 = next entry).
- R11: After reset, `m_valid`, `busy`, `done` and `mem_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Table field write strobe |
| cfg_sel | input | 3 | Table entry being written |
| cfg_field | input | 3 | Field code within the entry |
| cfg_wdata | input | 32 | Field value, low bits used |
| start | input | 1 | Begin a chain, one-cycle pulse |
| start_sel | input | 3 | First entry of the chain |
| busy | output | 1 | A chain is being processed |
| done | output | 1 | One-cycle end-of-chain pulse |
| mem_en | output | 1 | Memory read enable |
| mem_addr | output | 12 | Memory read address |
| mem_rdata | input | 32 | Memory read data, one cycle after `mem_en` |
| m_valid | output | 1 | Stream beat valid |
| m_data | output | 32 | Stream beat data |
| m_ready | input | 1 | Stream sink ready |

## Verification
The first pattern uses unit and power-of-two steps with the sink always ready. It shows the address nesting order directly and measures the one-word-per-cycle rate and the exact cycle of `done`. The second pattern uses an odd inner step and a negative outer step, with a base near the top of memory and a sink that stalls irregularly. It separates correct modulo wrap and hold-under-stall from designs that drop or duplicate a word when the skid register fills. Further patterns cover a chain of three entries, empty entries both at the end of a chain and in the middle of one, and a second `start` during a busy transfer. These show that links are followed, that empty entries emit nothing, and that a stray start is ignored.

// File: rtl/dmm_pkg.sv
package dmm_pkg;
  parameter int ADDR_W   = 12;
  parameter int SIZE_W   = 8;
  parameter int IDX_W    = 3;
  parameter int NUM_DESC = 1 << IDX_W;
  parameter int NUM_DIMS = 3;
  parameter int WORD_W   = 32;
  parameter int FIELD_W  = 3;

  typedef enum logic [FIELD_W-1:0] {
    FLD_BASE   = 3'd0,
    FLD_CNT0   = 3'd1,
    FLD_CNT1   = 3'd2,
    FLD_CNT2   = 3'd3,
    FLD_STEP0  = 3'd4,
    FLD_STEP1  = 3'd5,
    FLD_STEP2  = 3'd6,
    FLD_LINK   = 3'd7
  } field_e;

  typedef struct packed {
    logic [ADDR_W-1:0]                 base;
    logic [NUM_DIMS-1:0][SIZE_W-1:0]   cnt;
    logic [NUM_DIMS-1:0][ADDR_W-1:0]   step;
    logic                              link_en;
    logic [IDX_W-1:0]                  link_idx;
  } desc_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_RUN   = 2'd2,
    ST_DRAIN = 2'd3
  } mover_state_e;
endpackage

// File: rtl/dmm_desc_table.sv
module dmm_desc_table
  import dmm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_sel,
  input  logic [FIELD_W-1:0]   cfg_field,
  input  logic [WORD_W-1:0]    cfg_wdata,
  input  logic [IDX_W-1:0]     rd_sel,
  output desc_t                rd_desc
);
  desc_t entry_arr [NUM_DESC];

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_entry
    desc_t ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (cfg_we && (cfg_sel == IDX_W'(g))) begin
        case (field_e'(cfg_field))
          FLD_BASE:  ent_q.base        <= cfg_wdata[ADDR_W-1:0];
          FLD_CNT0:  ent_q.cnt[0]      <= cfg_wdata[SIZE_W-1:0];
          FLD_CNT1:  ent_q.cnt[1]      <= cfg_wdata[SIZE_W-1:0];
          FLD_CNT2:  ent_q.cnt[2]      <= cfg_wdata[SIZE_W-1:0];
          FLD_STEP0: ent_q.step[0]     <= cfg_wdata[ADDR_W-1:0];
          FLD_STEP1: ent_q.step[1]     <= cfg_wdata[ADDR_W-1:0];
          FLD_STEP2: ent_q.step[2]     <= cfg_wdata[ADDR_W-1:0];
          FLD_LINK: begin
            ent_q.link_en  <= cfg_wdata[IDX_W];
            ent_q.link_idx <= cfg_wdata[IDX_W-1:0];
          end
          default: ;
        endcase
      end
    end
    assign entry_arr[g] = ent_q;
  end

  assign rd_desc = entry_arr[rd_sel];
endmodule

// File: rtl/dmm_addr_gen.sv
module dmm_addr_gen
  import dmm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  desc_t              load_desc,
  input  logic               adv,
  output logic [ADDR_W-1:0]  addr,
  output logic               last
);
  logic [NUM_DIMS-1:0][SIZE_W-1:0] idx_q;
  logic [NUM_DIMS-1:0][SIZE_W-1:0] cnt_q;
  logic [NUM_DIMS-1:0][ADDR_W-1:0] step_q;
  logic [ADDR_W-1:0] outer_q;   // base + i2*step2
  logic [ADDR_W-1:0] mid_q;     // outer + i1*step1
  logic [ADDR_W-1:0] addr_q;    // mid + i0*step0
  logic [NUM_DIMS-1:0] at_end;

  for (genvar d = 0; d < NUM_DIMS; d++) begin : g_end
    assign at_end[d] = (idx_q[d] == cnt_q[d] - SIZE_W'(1));
  end

  assign last = &at_end;
  assign addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      cnt_q   <= '0;
      step_q  <= '0;
      outer_q <= '0;
      mid_q   <= '0;
      addr_q  <= '0;
    end else if (load) begin
      idx_q   <= '0;
      cnt_q   <= load_desc.cnt;
      step_q  <= load_desc.step;
      outer_q <= load_desc.base;
      mid_q   <= load_desc.base;
      addr_q  <= load_desc.base;
    end else if (adv) begin
      if (!at_end[0]) begin
        idx_q[0] <= idx_q[0] + SIZE_W'(1);
        addr_q   <= addr_q + step_q[0];
      end else if (!at_end[1]) begin
        idx_q[0] <= '0;
        idx_q[1] <= idx_q[1] + SIZE_W'(1);
        mid_q    <= mid_q + step_q[1];
        addr_q   <= mid_q + step_q[1];
      end else begin
        idx_q[0] <= '0;
        idx_q[1] <= '0;
        idx_q[2] <= idx_q[2] + SIZE_W'(1);
        outer_q  <= outer_q + step_q[2];
        mid_q    <= outer_q + step_q[2];
        addr_q   <= outer_q + step_q[2];
      end
    end
  end
endmodule

// File: rtl/dmm_out_stage.sv
module dmm_out_stage #(
  parameter int W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  output logic [1:0]    occ
);
  logic         head_v, skid_v;
  logic [W-1:0] head_d, skid_d;
  logic         pop;

  assign pop       = head_v && out_ready;
  assign out_valid = head_v;
  assign out_data  = head_d;
  assign occ       = 2'(head_v) + 2'(skid_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_v <= 1'b0;
      skid_v <= 1'b0;
      head_d <= '0;
      skid_d <= '0;
    end else if (!head_v) begin
      head_v <= in_valid;
      if (in_valid) head_d <= in_data;
    end else if (pop) begin
      if (skid_v) begin
        head_d <= skid_d;
        skid_v <= in_valid;
        if (in_valid) skid_d <= in_data;
      end else begin
        head_v <= in_valid;
        if (in_valid) head_d <= in_data;
      end
    end else if (in_valid) begin
      skid_v <= 1'b1;
      skid_d <= in_data;
    end
  end
endmodule

// File: rtl/dma_mm2s_mover.sv
module dma_mm2s_mover
  import dmm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_sel,
  input  logic [FIELD_W-1:0]   cfg_field,
  input  logic [WORD_W-1:0]    cfg_wdata,
  input  logic                 start,
  input  logic [IDX_W-1:0]     start_sel,
  output logic                 busy,
  output logic                 done,
  output logic                 mem_en,
  output logic [ADDR_W-1:0]    mem_addr,
  input  logic [WORD_W-1:0]    mem_rdata,
  output logic                 m_valid,
  output logic [WORD_W-1:0]    m_data,
  input  logic                 m_ready
);
  mover_state_e      state_q;
  logic [IDX_W-1:0]  cur_q;
  logic              lnk_en_q;
  logic [IDX_W-1:0]  lnk_idx_q;
  logic              inflight_q;
  desc_t             tbl_desc;
  logic              empty_cnt;
  logic              gen_load, gen_last, issue, pop, drained;
  logic [1:0]        occ;
  logic [2:0]        need;

  dmm_desc_table u_table (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .rd_sel(cur_q), .rd_desc(tbl_desc)
  );

  always_comb begin
    empty_cnt = 1'b0;
    for (int d = 0; d < NUM_DIMS; d++) begin
      if (tbl_desc.cnt[d] == '0) empty_cnt = 1'b1;
    end
  end

  assign gen_load = (state_q == ST_LOAD) && !empty_cnt;

  dmm_addr_gen u_gen (
    .clk(clk), .rst_n(rst_n),
    .load(gen_load), .load_desc(tbl_desc),
    .adv(issue), .addr(mem_addr), .last(gen_last)
  );

  dmm_out_stage #(.W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(inflight_q), .in_data(mem_rdata),
    .out_ready(m_ready), .out_valid(m_valid), .out_data(m_data), .occ(occ)
  );

  // A read may issue only if its data is sure to find a free slot.
  assign pop     = m_valid && m_ready;
  assign need    = {1'b0, occ} + {2'b00, inflight_q};
  assign issue   = (state_q == ST_RUN) && (need <= ({2'b00, pop} + 3'd1));
  assign mem_en  = issue;
  assign drained = (occ == 2'd0) && !inflight_q;
  assign done    = (state_q == ST_DRAIN) && drained;
  assign busy    = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cur_q      <= '0;
      lnk_en_q   <= 1'b0;
      lnk_idx_q  <= '0;
      inflight_q <= 1'b0;
    end else begin
      inflight_q <= issue;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            cur_q   <= start_sel;
            state_q <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          lnk_en_q  <= tbl_desc.link_en;
          lnk_idx_q <= tbl_desc.link_idx;
          if (!empty_cnt) begin
            state_q <= ST_RUN;
          end else if (tbl_desc.link_en) begin
            cur_q <= tbl_desc.link_idx;
          end else begin
            state_q <= ST_DRAIN;
          end
        end
        ST_RUN: begin
          if (issue && gen_last) begin
            if (lnk_en_q) begin
              cur_q   <= lnk_idx_q;
              state_q <= ST_LOAD;
            end else begin
              state_q <= ST_DRAIN;
            end
          end
        end
        ST_DRAIN: begin
          if (drained) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmm_checker.sv
module dmm_checker
  import dmm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              mem_en,
  input logic              m_valid,
  input logic              m_ready,
  input logic [WORD_W-1:0] m_data
);
  a_r3_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  a_r5_read_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> busy);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!m_valid && !mem_en));

  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> busy);
endmodule

bind dma_mm2s_mover dmm_checker chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .mem_en(mem_en), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
);

// File: tb/dma_mm2s_mover_tb_top.sv
module dma_mm2s_mover_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [2:0]  cfg_field = '0;
  logic [31:0] cfg_wdata = '0;
  logic        start = 1'b0;
  logic [2:0]  start_sel = '0;
  logic        busy, done, mem_en, m_valid;
  logic [11:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic [31:0] m_data;
  logic        m_ready = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_mm2s_mover dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .start(start), .start_sel(start_sel), .busy(busy), .done(done),
    .mem_en(mem_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .m_valid(m_valid), .m_data(m_data), .m_ready(m_ready)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  int d_base[8], d_c0[8], d_c1[8], d_c2[8], d_s0[8], d_s1[8], d_s2[8], d_len[8], d_lidx[8];
  logic [31:0] exp_q[$];

  int beats = 0, first_hs = -1, last_hs = -1, done_cnt = 0, done_cyc = -1;
  logic held = 1'b0, prev_done = 1'b0;
  logic [31:0] held_data = '0;

  function automatic logic [31:0] mem_word(logic [11:0] a);
    return {8'h5A, a, ~a};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model, one cycle read latency
  initial forever begin
    @(posedge clk);
    if (mem_en) mem_rdata <= mem_word(mem_addr);
  end

  always @(posedge clk) cyc <= cyc + 1;

  // sink ready driver
  initial forever begin
    @(posedge clk);
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_ready = (ready_mode == 0) ? 1'b1 : (lfsr[1:0] != 2'b00 && lfsr[4:3] != 2'b11);
  end

  // monitor: scoreboard pop, hold check, done tracking
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (held) begin
        check(m_valid === 1'b1, "R3", "valid dropped under stall", m_valid, 1);
        check(m_data === held_data, "R3", "data changed under stall", m_data, held_data);
      end
      held = m_valid && !m_ready;
      held_data = m_data;
      if (m_valid && m_ready) begin
        beats++;
        if (first_hs < 0) first_hs = cyc;
        last_hs = cyc;
        if (exp_q.size() == 0) begin
          check(1'b0, "R1", "unexpected beat", m_data, 0);
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          check(m_data === e, "R1/R2", "beat data", m_data, e);
        end
      end
      if (done) begin
        done_cnt++;
        done_cyc = cyc;
        check(!prev_done, "R8", "done longer than one cycle", 1, 0);
      end
      prev_done = done;
    end
  end

  task automatic wr(int idx, int fld, int val);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_sel = 3'(idx); cfg_field = 3'(fld); cfg_wdata = 32'(val);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic set_desc(int idx, int base, int c0, int c1, int c2,
                          int s0, int s1, int s2, int len, int lidx);
    d_base[idx] = base; d_c0[idx] = c0; d_c1[idx] = c1; d_c2[idx] = c2;
    d_s0[idx] = s0; d_s1[idx] = s1; d_s2[idx] = s2; d_len[idx] = len; d_lidx[idx] = lidx;
    // R10 field codes: 0 base, 1..3 counts, 4..6 steps, 7 link {en, idx}
    wr(idx, 0, base); wr(idx, 1, c0); wr(idx, 2, c1); wr(idx, 3, c2);
    wr(idx, 4, s0);   wr(idx, 5, s1); wr(idx, 6, s2); wr(idx, 7, (len << 3) | lidx);
  endtask

  function automatic int expect_chain(int idx);
    int n = 0;
    int cur = idx;
    for (int guard = 0; guard < 16; guard++) begin
      if (d_c0[cur] != 0 && d_c1[cur] != 0 && d_c2[cur] != 0)
        for (int i2 = 0; i2 < d_c2[cur]; i2++)
          for (int i1 = 0; i1 < d_c1[cur]; i1++)
            for (int i0 = 0; i0 < d_c0[cur]; i0++) begin
              int a = d_base[cur] + i0*d_s0[cur] + i1*d_s1[cur] + i2*d_s2[cur];
              exp_q.push_back(mem_word(12'(a)));
              n++;
            end
      if (d_len[cur] == 0) break;
      cur = d_lidx[cur];
    end
    return n;
  endfunction

  task automatic run_chain(int idx, int mode, int stray, string req, output int nexp);
    int start_cyc;
    int d0;
    nexp = expect_chain(idx);
    ready_mode = mode;
    beats = 0; first_hs = -1; last_hs = -1; d0 = done_cnt; done_cyc = -1;
    @(posedge clk); #1;
    start = 1'b1; start_sel = 3'(idx);
    @(posedge clk); #1;
    start = 1'b0;
    start_cyc = cyc;
    if (stray != 0) begin
      repeat (6) @(posedge clk);
      #1; start = 1'b1; start_sel = 3'(stray);
      @(posedge clk); #1; start = 1'b0;
    end
    for (int g = 0; g < 20000 && done_cnt == d0; g++) @(posedge clk);
    repeat (6) @(posedge clk);
    @(negedge clk);
    check(done_cnt - d0 == 1, req, "done pulse count", done_cnt - d0, 1);
    check(beats == nexp, req, "beat count", beats, nexp);
    check(exp_q.size() == 0, "R1", "leftover expected beats", exp_q.size(), 0);
    check(busy == 1'b0, "R8", "busy after done", busy, 0);
    if (nexp > 0)
      check(done_cyc == last_hs + 1, "R8", "done timing vs last beat", done_cyc, last_hs + 1);
    else
      check(done_cyc == start_cyc + 1, "R7", "empty chain done timing", done_cyc, start_cyc + 1);
    exp_q.delete();
  endtask

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(m_valid === 1'b0, "R11", "m_valid after reset", m_valid, 0);
    check(busy === 1'b0, "R11", "busy after reset", busy, 0);
    check(done === 1'b0, "R11", "done after reset", done, 0);
    check(mem_en === 1'b0, "R11", "mem_en after reset", mem_en, 0);

    // R2/R4: plain nesting, always ready, throughput
    set_desc(0, 'h100, 4, 3, 2, 1, 'h10, 'h100, 0, 0);
    run_chain(0, 0, 0, "R2", n);
    check(last_hs - first_hs == n - 1, "R4", "cycles across descriptor", last_hs - first_hs, n - 1);

    // R2/R3: odd step, negative outer step, address wrap, stalls
    set_desc(1, 'hFF8, 5, 4, 3, 3, 'h40, 'hFF0, 0, 0);
    run_chain(1, 1, 0, "R3", n);

    // R6: chain 2 -> 3 -> 1 with stalls
    set_desc(2, 'h020, 2, 2, 2, 7, 'h100, 'h9, 1, 3);
    set_desc(3, 'h7F0, 6, 1, 1, 'hFFF, 0, 0, 1, 1);
    run_chain(2, 1, 0, "R6", n);

    // R7: empty entry ending a chain, and empty entry inside a chain
    set_desc(4, 'h300, 3, 0, 2, 1, 1, 1, 0, 0);
    run_chain(4, 0, 0, "R7", n);
    set_desc(5, 'h300, 0, 2, 2, 1, 1, 1, 1, 6);
    set_desc(6, 'hABC, 3, 2, 1, 2, 'h20, 0, 0, 0);
    run_chain(5, 1, 0, "R7", n);

    // R9: stray start during a busy transfer, always ready
    run_chain(0, 0, 4, "R9", n);
    // R5: reads stopped once idle
    check(mem_en === 1'b0, "R5", "mem_en while idle", mem_en, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", WATCHDOG, WATCHDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule